// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block runs ahead of an execution stage and keeps a small first-in-first-out store of instruction bytes filled, so the consumer rarely waits for memory. It holds a code segment value and a 16-bit fetch offset. The 20-bit physical fetch address is the segment shifted left by four bits plus the offset. Fetches are 16-bit word reads on a request/acknowledge memory port. A fetch from an odd offset keeps only the upper byte of the word. A fetch from an even offset keeps both bytes.

The consumer sees the oldest queued byte through a valid/ready handshake and may take one byte per cycle while refilling goes on in parallel. The queue holds six bytes. A new fetch starts only when at least two slots are free, so a returning word always fits. A one-cycle flush pulse carries a new segment and offset after a control transfer. It empties the queue, discards the data of any fetch still on the bus, and redirects fetching.

Top module: `pfq_unit`

## Requirements
- R1: While `mem_req` is high, `mem_addr` equals ((segment << 4) + offset) mod 2^20, taken at the time the fetch was issued. After reset the segment and offset are both 0.
- R2: A fetch from an even offset queues `mem_rdata[7:0]` first and then `mem_rdata[15:8]`, and advances the offset by two. The low data byte is the byte at the even address.
- R3: A fetch from an odd offset queues only `mem_rdata[15:8]` and advances the offset by one.
- R4: The offset wraps modulo 65536 and never changes the segment. After offset 0xFFFF the next byte comes from offset 0x0000 of the same segment.
- R5: The queue never holds more than six bytes. A fetch is issued only when the queue holds four or fewer bytes. This holds even while the consumer is stalled.
- R6: Only one fetch is outstanding at a time. `mem_req` stays high with a stable `mem_addr` until the cycle `mem_ack` is sampled high, and falls on the following cycle.
- R7: `byte_valid` is high whenever the queue holds a byte and no flush is present, and `byte_data` is then the oldest byte. A byte leaves only on a cycle with `byte_valid` and `byte_ready` both high. A byte can enter and leave in the same cycle. Bytes come out in address order.
- R8: In the cycle `flush` is high and in the cycle after, `byte_valid` is low. The queue is emptied. Data acknowledged for a fetch issued before the flush is discarded. Fetching restarts from the new segment and offset.
- R9: During reset `mem_req` and `byte_valid` are low. After reset, fetching starts by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | One-cycle redirect pulse |
| flush_seg | input | 16 | New code segment value, taken with `flush` |
| flush_ofs | input | 16 | New fetch offset, taken with `flush` |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | 20 | Physical byte address of the fetch |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` valid this cycle |
| mem_rdata | input | 16 | Read word; low byte is the even address |
| byte_valid | output | 1 | Oldest queued byte is presented |
| byte_data | output | 8 | Oldest queued byte |
| byte_ready | input | 1 | Consumer takes the presented byte |

## Verification
Two cases are hardest to reach from the ports. The first is a flush that lands while a fetch is still waiting on memory. The bench stretches the memory latency to six cycles and watches for a request that has just been accepted by the memory model. It then flushes to a new target, so any stale word that reached the queue would break the expected byte stream. The second is the five-byte occupancy where the two-free rule must hold off a fetch. The bench holds `byte_ready` low until the queue settles, then releases exactly one byte at a time. Between releases it counts acknowledged fetches, starting from both an odd and an even offset.

// File: rtl/pfq_pkg.sv
// Package: shared constants and types of the prefetch queue unit.
// Assumes a byte-addressed memory returning one 16-bit word per fetch.
package pfq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;
endpackage

// File: rtl/pfq_addr_gen.sv
// Module: pfq_addr_gen
// Forms the physical fetch address from a segment value and an offset.
// Assumes SEG_W + SHIFT <= PA_W; the sum is truncated to PA_W bits.
module pfq_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  pa
);
    // Shifted segment base plus zero-extended offset, modulo 2^PA_W
    assign pa = PA_W'({seg, {SHIFT{1'b0}}}) + PA_W'(ofs);
endmodule

// File: rtl/pfq_byte_fifo.sv
// Module: pfq_byte_fifo
// Circular byte store that accepts one or two bytes per cycle and releases one.
// Assumes the writer never pushes more than the free space (the fetch
// controller guarantees it). Clear has priority over any push or pop.
module pfq_byte_fifo #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic              wr_two,
    input  logic [DATA_W-1:0] wr_lo,
    input  logic [DATA_W-1:0] wr_hi,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  wr_ptr_p1;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  count_nx;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                  input int unsigned n);
        int unsigned s;
        s = 32'(p) + n;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    assign wr_ptr_p1 = ptr_step(wr_ptr_q, 1);

    // Occupancy after this cycle's push and pop
    always_comb begin
        int c;
        c = int'(count_q);
        if (wr_en)  c = c + (wr_two ? 2 : 1);
        if (rd_en)  c = c - 1;
        count_nx = CNT_W'(c);
    end

    // Byte storage: first byte at the write pointer, second one slot later
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && !clear && wr_ptr_q == PTR_W'(i))
                slot_q[i] <= wr_lo;
            else if (wr_en && !clear && wr_two && wr_ptr_p1 == PTR_W'(i))
                slot_q[i] <= wr_hi;
        end
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (rd_en) rd_ptr_q <= ptr_step(rd_ptr_q, 1);
            if (wr_en) wr_ptr_q <= ptr_step(wr_ptr_q, wr_two ? 2 : 1);
            count_q <= count_nx;
        end
    end

    assign rd_data = slot_q[rd_ptr_q];
    assign count   = count_q;
endmodule

// File: rtl/pfq_fetch_ctrl.sv
// Module: pfq_fetch_ctrl
// Holds segment and offset, issues one word fetch at a time when the
// queue has room for two bytes, and steers the returned bytes into the queue.
// Assumes mem_ack comes only while mem_req is high. A flush during a fetch
// lets the bus cycle finish but marks its data to be discarded.
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFS_W   = 16,
    parameter int PA_W    = 20,
    parameter int DEPTH   = 6,
    parameter int CNT_W   = 3,
    parameter logic [SEG_W-1:0] RST_SEG = '0,
    parameter logic [OFS_W-1:0] RST_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SEG_W-1:0]  flush_seg,
    input  logic [OFS_W-1:0]  flush_ofs,
    input  logic [CNT_W-1:0]  q_count,
    input  logic [PA_W-1:0]   pa_in,
    output logic [SEG_W-1:0]  seg_out,
    output logic [OFS_W-1:0]  ofs_out,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic              wr_two,
    output logic [BYTE_W-1:0] wr_lo,
    output logic [BYTE_W-1:0] wr_hi
);
    fetch_state_e     state_q;
    logic [SEG_W-1:0] seg_q;
    logic [OFS_W-1:0] ofs_q;
    logic [PA_W-1:0]  addr_q;
    logic             odd_q;
    logic             drop_q;
    logic             issue;
    logic             accept;

    // Start a fetch when idle, not redirecting, and two slots are free
    assign issue  = (state_q == FS_IDLE) && !flush && (q_count <= CNT_W'(DEPTH - 2));
    // Keep returned data only if no flush came since the fetch was issued
    assign accept = (state_q == FS_WAIT) && mem_ack && !drop_q && !flush;

    // Fetch sequencing, address latch and discard marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
            odd_q   <= 1'b0;
            drop_q  <= 1'b0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (issue) begin
                        state_q <= FS_WAIT;
                        addr_q  <= pa_in;
                        odd_q   <= ofs_q[0];
                        drop_q  <= 1'b0;
                    end
                end
                FS_WAIT: begin
                    if (mem_ack) begin
                        state_q <= FS_IDLE;
                        drop_q  <= 1'b0;
                    end else if (flush) begin
                        drop_q  <= 1'b1;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Segment and offset: redirect wins, else advance by the bytes kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= RST_SEG;
            ofs_q <= RST_OFS;
        end else if (flush) begin
            seg_q <= flush_seg;
            ofs_q <= flush_ofs;
        end else if (accept) begin
            ofs_q <= ofs_q + (odd_q ? OFS_W'(1) : OFS_W'(2));
        end
    end

    assign seg_out  = seg_q;
    assign ofs_out  = ofs_q;
    assign mem_req  = (state_q == FS_WAIT);
    assign mem_addr = addr_q;
    assign wr_en    = accept;
    assign wr_two   = !odd_q;
    assign wr_lo    = odd_q ? mem_rdata[WORD_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];
    assign wr_hi    = mem_rdata[WORD_W-1:BYTE_W];
endmodule

// File: rtl/pfq_unit.sv
// Module: pfq_unit (top)
// Instruction prefetch queue: segment-relative word fetching into a
// six-byte queue with a one-byte-per-cycle valid/ready output and flush.
// Assumes a flush is a single-cycle pulse; no byte is handed out in that cycle.
module pfq_unit
    import pfq_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PA_W      = 20,
    parameter int DEPTH     = 6,
    parameter logic [SEG_W-1:0] RST_SEG = '0,
    parameter logic [OFS_W-1:0] RST_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SEG_W-1:0]  flush_seg,
    input  logic [OFS_W-1:0]  flush_ofs,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_ready
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  q_count;
    logic [SEG_W-1:0]  cur_seg;
    logic [OFS_W-1:0]  cur_ofs;
    logic [PA_W-1:0]   cur_pa;
    logic              wr_en;
    logic              wr_two;
    logic [BYTE_W-1:0] wr_lo;
    logic [BYTE_W-1:0] wr_hi;
    logic              pop;

    // Output handshake: present while non-empty and not redirecting
    assign byte_valid = (q_count != '0) && !flush;
    assign pop        = byte_valid && byte_ready;

    pfq_addr_gen #(
        .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SEG_SHIFT), .PA_W(PA_W)
    ) u_agen (
        .seg(cur_seg), .ofs(cur_ofs), .pa(cur_pa)
    );

    pfq_fetch_ctrl #(
        .SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W), .DEPTH(DEPTH),
        .CNT_W(CNT_W), .RST_SEG(RST_SEG), .RST_OFS(RST_OFS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .flush_seg(flush_seg), .flush_ofs(flush_ofs),
        .q_count(q_count), .pa_in(cur_pa),
        .seg_out(cur_seg), .ofs_out(cur_ofs),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_two(wr_two), .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    pfq_byte_fifo #(
        .DEPTH(DEPTH), .DATA_W(BYTE_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(flush),
        .wr_en(wr_en), .wr_two(wr_two), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .rd_en(pop), .rd_data(byte_data), .count(q_count)
    );
endmodule

// File: rtl/pfq_unit_chk.sv
// Module: pfq_unit_chk
// Protocol and occupancy properties of the prefetch queue, bound to pfq_unit.
// Assumes it observes the top's ports and the queue occupancy.
module pfq_unit_chk #(
    parameter int PA_W  = 20,
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [PA_W-1:0]  mem_addr,
    input logic             byte_valid,
    input logic             byte_ready,
    input logic [7:0]       byte_data,
    input logic [CNT_W-1:0] q_count
);
    // R5
    q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    // R5
    fetch_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> ($past(q_count) <= CNT_W'(DEPTH - 2)));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> (flush || (byte_valid && $stable(byte_data))));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !byte_valid);
endmodule

bind pfq_unit pfq_unit_chk #(
    .PA_W(PA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .q_count(q_count)
);

// File: tb/sim_pfq_unit.sv
// Bench: scoreboard of expected instruction bytes per redirect target,
// a behavioural memory with adjustable latency, and a port-level monitor.
module sim_pfq_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] flush_seg = '0;
    logic [15:0] flush_ofs = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ready = 1'b0;

    int checks = 0;
    int fails = 0;
    int hs = 0;
    int acks = 0;
    int lat = 1;
    int mdl_wait = 0;
    bit mdl_busy = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    pfq_unit u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .flush_seg(flush_seg), .flush_ofs(flush_ofs),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready)
    );

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h9};
    endfunction

    function automatic logic [19:0] pa_of(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_exp(input logic [15:0] s, input logic [15:0] o);
        exp_q.delete();
        for (int k = 0; k < 96; k++) exp_q.push_back(mb(pa_of(s, o + 16'(k))));
    endtask

    task automatic flush_to(input logic [15:0] s, input logic [15:0] o,
                            input bit chk_addr, input logic [19:0] exp_addr);
        @(negedge clk);
        flush = 1'b1; flush_seg = s; flush_ofs = o;
        load_exp(s, o);
        #(CLK_P/4);
        chk(byte_valid == 1'b0, "R8", "valid in flush cycle", byte_valid, 0);
        @(negedge clk);
        flush = 1'b0;
        #(CLK_P/4);
        chk(byte_valid == 1'b0, "R8", "valid after flush", byte_valid, 0);
        if (chk_addr) begin
            @(negedge clk);
            #(CLK_P/4);
            chk(mem_req == 1'b1, "R1", "request after flush", mem_req, 1);
            chk(mem_addr == exp_addr, "R1", "first fetch address", mem_addr, exp_addr);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_one();
        @(negedge clk); byte_ready = 1'b1;
        @(negedge clk); byte_ready = 1'b0;
    endtask

    // Memory model: acknowledges after lat cycles, checks address stability
    initial begin
        logic [19:0] a0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mdl_busy = 0;
            end else if (mem_req) begin
                if (!mdl_busy) begin
                    mdl_busy = 1; a0 = mem_addr; mdl_wait = 0;
                end
                if (mdl_wait >= lat - 1) begin
                    chk(mem_addr == a0, "R6", "address held until ack", mem_addr, a0);
                    mem_rdata = {mb(a0 | 20'h1), mb(a0 & 20'hFFFFE)};
                    mem_ack = 1'b1;
                    acks++;
                end else begin
                    mdl_wait++;
                end
            end
        end
    end

    // Monitor: compare each handed-out byte against the scoreboard (R2 R3 R4 R7)
    initial begin
        logic [7:0] e;
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (rst_n && byte_valid && byte_ready) begin
                hs++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "byte with empty scoreboard", byte_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(byte_data == e, "R7", "byte stream data", byte_data, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int h;
        int a;
        // R9: reset state, then autonomous fetching from segment 0 offset 0
        cycles(3);
        #(CLK_P/4);
        chk(mem_req == 1'b0, "R9", "mem_req in reset", mem_req, 0);
        chk(byte_valid == 1'b0, "R9", "byte_valid in reset", byte_valid, 0);
        load_exp(16'h0000, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1; byte_ready = 1'b1;
        h = hs;
        cycles(30);
        chk(hs - h >= 20, "R9", "bytes after reset", hs - h, 20);

        // R1 R2: even offset stream with full-rate consumer
        @(negedge clk); byte_ready = 1'b0;
        cycles(20);
        flush_to(16'h1234, 16'h0010, 1, 20'h12350);
        @(negedge clk); byte_ready = 1'b1;
        h = hs;
        cycles(40);
        chk(hs - h >= 30, "R7", "sustained byte rate", hs - h, 30);

        // R3 R5: odd start fills to five bytes, one pop opens room
        @(negedge clk); byte_ready = 1'b0;
        cycles(20);
        a = acks;
        flush_to(16'h0800, 16'h0033, 1, 20'h08033);
        cycles(30);
        #(CLK_P/4);
        chk(acks - a == 3, "R5", "fetches with odd start, stalled", acks - a, 3);
        chk(mem_req == 1'b0, "R5", "idle at five bytes", mem_req, 0);
        pop_one();
        cycles(10);
        chk(acks - a == 4, "R5", "fetch after one pop from five", acks - a, 4);
        @(negedge clk); byte_ready = 1'b1;
        cycles(20);

        // R2 R5: even start fills to six, needs two pops
        @(negedge clk); byte_ready = 1'b0;
        cycles(20);
        a = acks;
        flush_to(16'h2000, 16'h0100, 1, 20'h20100);
        cycles(30);
        chk(acks - a == 3, "R5", "fetches with even start, stalled", acks - a, 3);
        pop_one();
        cycles(10);
        chk(acks - a == 3, "R5", "no fetch with one free slot", acks - a, 3);
        pop_one();
        cycles(10);
        chk(acks - a == 4, "R5", "fetch with two free slots", acks - a, 4);
        @(negedge clk); byte_ready = 1'b1;
        cycles(20);

        // R4: offset wrap inside the top segment, address truncation
        @(negedge clk); byte_ready = 1'b0;
        cycles(20);
        flush_to(16'hFFFF, 16'hFFFD, 1, 20'h0FFED);
        @(negedge clk); byte_ready = 1'b1;
        h = hs;
        cycles(40);
        chk(hs - h >= 20, "R4", "bytes across wrap", hs - h, 20);

        // R8: flush while a slow fetch is outstanding
        @(negedge clk); lat = 6;
        flush_to(16'h3000, 16'h0000, 0, 20'h0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #(CLK_P/4);
            if (mem_req && mdl_busy && mdl_wait == 1) break;
        end
        chk(mem_req == 1'b1, "R8", "fetch outstanding before flush", mem_req, 1);
        flush_to(16'h4000, 16'h0021, 0, 20'h0);
        h = hs;
        cycles(80);
        chk(hs - h >= 10, "R8", "restart after flush", hs - h, 10);

        // R7: intermittent consumer with moderate latency
        @(negedge clk); lat = 3;
        flush_to(16'h5555, 16'hAAAA, 0, 20'h0);
        h = hs;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            byte_ready = (i % 3 != 1);
        end
        chk(hs - h >= 15, "R7", "bytes with stalling consumer", hs - h, 15);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule